// File: doc/BRIEF.md
# Real-Time Clock Register File

This block is the register front end of a small real-time clock. Software reaches it through two ports: an index port that picks one of fourteen byte locations, and a data port that reads or writes the picked location. The ten lowest locations are plain time and date bytes. The four above them are status registers. Status A carries the oscillator and rate selection and an update-in-progress flag. Status B carries the mode bits and the periodic-interrupt enable. Status C and D read as zero.

A separate load port writes every time field in one cycle, for example from a host clock at start-up. While status B has its periodic-interrupt enable set, a built-in timer raises a one-cycle interrupt request every `PERIOD_CYCLES` clock cycles. The timer starts and stops as soon as status B is written.

Any access the block does not support produces a one-cycle `bad_access` pulse and changes no state. This covers an out-of-range index, a status A value other than its fixed setting, a status B value that touches fixed mode bits, and any write to C or D.

Top module: `rtc_regfile`

## Requirements
- R1: An index write with a value from 0 to 13 selects that location. A value of 14 or more pulses `bad_access` in the following cycle and leaves the selected location unchanged.
- R2: Locations 0 to 9 are plain byte storage. A data write stores the byte without flagging anything. A read strobe returns the selected byte on `rd_data` in the next cycle, and `rd_data` holds its value between reads.
- R3: Status A (location 10) resets to 0x26. Each read flips its bit 7 (update in progress), and the read returns the value after the flip, so the first read after reset gives 0xA6.
- R4: A write to status A is accepted only when the value is exactly 0x26. Any other value pulses `bad_access` and leaves status A unchanged.
- R5: Status B (location 11) resets to 0x46. In that value, bit 6 is the periodic-interrupt enable, bit 2 selects binary mode and bit 1 selects 24-hour mode.
- R6: A write to status B is accepted when the value, with bits 6 and 3 masked off, equals 0x06. Any other value pulses `bad_access` and changes neither status B nor the timer.
- R7: Locations 12 and 13 always read as zero. Writes to them pulse `bad_access`.
- R8: A load strobe stores seconds at 0, minutes at 2, hours at 4, weekday plus one at 6, day of month at 7, month plus one at 8 and year at 9. The weekday and month inputs are zero-based. Locations 1, 3 and 5 are not touched.
- R9: While enabled, `irq` is a single-cycle pulse that repeats every `PERIOD_CYCLES` cycles. The first pulse comes `PERIOD_CYCLES` cycles after the edge that enabled the timer.
- R10: An accepted status B write with bit 6 set does not restart a timer that is already running. An accepted write with bit 6 clear stops the timer at once, and no pulse appears at or after that edge until the timer is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_we | input | 1 | Index write strobe |
| idx_wdata | input | 8 | Index value |
| dat_we | input | 1 | Data write strobe for the selected location |
| dat_re | input | 1 | Data read strobe for the selected location |
| dat_wdata | input | 8 | Data write value |
| rd_data | output | 8 | Read result, registered |
| bad_access | output | 1 | One-cycle pulse after an unsupported access |
| ld_en | input | 1 | Load all time fields |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_wday | input | 8 | Weekday, zero-based |
| ld_mday | input | 8 | Day of month |
| ld_mon | input | 8 | Month, zero-based |
| ld_year | input | 8 | Year |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
Read data and the access flag each pass through one register, so they are due exactly one cycle after their strobe. The bench drives strobes on the falling edge and samples on the next falling edge, after the single rising edge that captures the result.

For the interrupt, the bench records the number of the rising edge that took the status B write. It then counts rising edges up to the falling edge where `irq` is seen, and expects exactly `PERIOD_CYCLES` between enable and the first pulse and between consecutive pulses. Index, status A and status B are swept over all 256 write values, and the expected data and flag come from a byte model held in the bench.

// File: rtl/rtc_regfile_pkg.sv
// Shared constants for the real-time clock register file.
// Assumes the status registers sit directly above the time/date bytes.
package rtc_regfile_pkg;
    // Offsets of the status registers above the last time/date byte
    localparam int unsigned STAT_A_OFS = 0;
    localparam int unsigned STAT_B_OFS = 1;
    localparam int unsigned STAT_C_OFS = 2;
    localparam int unsigned STAT_D_OFS = 3;
    localparam int unsigned NUM_STAT   = 4;

    // Fixed register values and bit positions
    localparam logic [7:0] STAT_A_INIT  = 8'h26;  // 32.768 kHz base, 1024 Hz rate
    localparam logic [7:0] STAT_B_INIT  = 8'h46;  // periodic enable, binary, 24 h
    localparam logic [7:0] STAT_B_SOFT  = 8'h48;  // bits software may change
    localparam int unsigned UIP_BIT     = 7;
    localparam int unsigned PIE_BIT     = 6;

    // Time/date byte slots written by the load port
    localparam int unsigned SLOT_SEC  = 0;
    localparam int unsigned SLOT_MIN  = 2;
    localparam int unsigned SLOT_HOUR = 4;
    localparam int unsigned SLOT_WDAY = 6;
    localparam int unsigned SLOT_MDAY = 7;
    localparam int unsigned SLOT_MON  = 8;
    localparam int unsigned SLOT_YEAR = 9;
endpackage

// File: rtl/rtc_index_reg.sv
// Index register: holds the selected location. It assumes the index port
// is 8 bits wide and rejects any value past the last location.
module rtc_index_reg #(
    parameter int unsigned NUM_LOC = 14,
    parameter int unsigned IDX_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_val,
    output logic [IDX_W-1:0] idx,
    output logic             reject
);
    localparam logic [7:0] MAX_IDX = 8'(NUM_LOC - 1);

    // Flag an index write that is out of range
    always_comb reject = wr_en && (wr_val > MAX_IDX);

    // Take an index write only when it is in range
    always_ff @(posedge clk) begin
        if (!rst_n)                idx <= '0;
        else if (wr_en && !reject) idx <= wr_val[IDX_W-1:0];
    end
endmodule

// File: rtl/rtc_time_store.sv
// Time/date byte array. It is written from the data port or the load port,
// and the load port wins on the slots it covers. Reads are combinational.
module rtc_time_store #(
    parameter int unsigned TIME_BYTES = 10,
    parameter int unsigned IDX_W      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_val,
    input  logic                       ld_en,
    input  logic [TIME_BYTES-1:0]      ld_mask,
    input  logic [TIME_BYTES-1:0][7:0] ld_vals,
    output logic [7:0]                 rd_byte
);
    logic [TIME_BYTES-1:0][7:0] mem_q;

    for (genvar i = 0; i < TIME_BYTES; i++) begin : g_byte
        // Update one byte from the load port or the data port
        always_ff @(posedge clk) begin
            if (!rst_n)                       mem_q[i] <= '0;
            else if (ld_en && ld_mask[i])     mem_q[i] <= ld_vals[i];
            else if (wr_en && idx == IDX_W'(i)) mem_q[i] <= wr_val;
        end
    end

    // Select the byte at the current index
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < TIME_BYTES; i++)
            if (idx == IDX_W'(i)) rd_byte = mem_q[i];
    end
endmodule

// File: rtl/rtc_status_regs.sv
// Status registers A to D. A has a single legal write value and flips its
// update-in-progress bit on each read. B accepts only changes to the
// interrupt and square-wave enables. C and D read zero and reject writes.
module rtc_status_regs
    import rtc_regfile_pkg::*;
#(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned BASE  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wr_val,
    output logic [7:0]       stat_a,
    output logic [7:0]       stat_b,
    output logic [7:0]       rd_byte,
    output logic             reject,
    output logic             pie_on,
    output logic             pie_off
);
    localparam logic [IDX_W-1:0] ADDR_A = IDX_W'(BASE + STAT_A_OFS);
    localparam logic [IDX_W-1:0] ADDR_B = IDX_W'(BASE + STAT_B_OFS);
    localparam logic [IDX_W-1:0] ADDR_C = IDX_W'(BASE + STAT_C_OFS);
    localparam logic [IDX_W-1:0] ADDR_D = IDX_W'(BASE + STAT_D_OFS);

    logic a_ok, b_ok, a_wr, b_wr;

    // Decode writes and check them against the fixed bits
    always_comb begin
        a_wr    = wr_en && idx == ADDR_A;
        b_wr    = wr_en && idx == ADDR_B;
        a_ok    = wr_val == STAT_A_INIT;
        b_ok    = (wr_val & ~STAT_B_SOFT) == (STAT_B_INIT & ~STAT_B_SOFT);
        reject  = (a_wr && !a_ok) || (b_wr && !b_ok) ||
                  (wr_en && (idx == ADDR_C || idx == ADDR_D));
        pie_on  = b_wr && b_ok && wr_val[PIE_BIT];
        pie_off = b_wr && b_ok && !wr_val[PIE_BIT];
    end

    // Status A: accepted write, otherwise flip the busy flag on a read
    always_ff @(posedge clk) begin
        if (!rst_n)                    stat_a <= STAT_A_INIT;
        else if (a_wr && a_ok)         stat_a <= wr_val;
        else if (rd_en && idx == ADDR_A) stat_a[UIP_BIT] <= ~stat_a[UIP_BIT];
    end

    // Status B: store accepted writes only
    always_ff @(posedge clk) begin
        if (!rst_n)            stat_b <= STAT_B_INIT;
        else if (b_wr && b_ok) stat_b <= wr_val;
    end

    // Read value, with the flag of A shown as it is after the flip
    always_comb begin
        rd_byte = '0;
        if (idx == ADDR_A) begin
            rd_byte          = stat_a;
            rd_byte[UIP_BIT] = ~stat_a[UIP_BIT];
        end else if (idx == ADDR_B) begin
            rd_byte = stat_b;
        end
    end
endmodule

// File: rtl/rtc_periodic_timer.sv
// Periodic interrupt timer. It runs from reset and pulses irq once every
// PERIOD cycles. A start while running is ignored; a stop takes effect at
// once. It assumes PERIOD is at least 2.
module rtc_periodic_timer #(
    parameter int unsigned PERIOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic running,
    output logic irq
);
    localparam int unsigned CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Run state and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b1;
            cnt_q   <= '0;
        end else if (stop) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            cnt_q   <= '0;
        end else if (running) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // One-cycle request at the end of each period, suppressed by a stop
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= running && !stop && cnt_q == LAST;
    end
endmodule

// File: rtl/rtc_regfile.sv
// Real-time clock register file top. It joins the index register, the
// time/date store, the status registers and the periodic timer, and
// registers the read data and the bad-access flag.
module rtc_regfile
    import rtc_regfile_pkg::*;
#(
    parameter int unsigned NUM_LOC       = 14,
    parameter int unsigned PERIOD_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic [7:0] idx_wdata,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] dat_wdata,
    output logic [7:0] rd_data,
    output logic       bad_access,
    input  logic       ld_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_mday,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    output logic       irq
);
    localparam int unsigned TIME_BYTES = NUM_LOC - NUM_STAT;
    localparam int unsigned IDX_W      = $clog2(NUM_LOC);
    localparam int unsigned ADDR_A     = TIME_BYTES + STAT_A_OFS;
    localparam int unsigned ADDR_B     = TIME_BYTES + STAT_B_OFS;
    localparam int unsigned ADDR_C     = TIME_BYTES + STAT_C_OFS;

    logic [IDX_W-1:0]           cur_idx;
    logic                       idx_bad, stat_bad, pie_on, pie_off, running;
    logic [7:0]                 time_byte, stat_byte, stat_a, stat_b;
    logic [TIME_BYTES-1:0]      ld_mask;
    logic [TIME_BYTES-1:0][7:0] ld_vals;

    rtc_index_reg #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .wr_en(idx_we), .wr_val(idx_wdata),
        .idx(cur_idx), .reject(idx_bad)
    );

    // Map the load fields onto their slots, with one-based weekday and month
    always_comb begin
        ld_mask = '0;
        ld_vals = '0;
        ld_mask[SLOT_SEC]  = 1'b1; ld_vals[SLOT_SEC]  = ld_sec;
        ld_mask[SLOT_MIN]  = 1'b1; ld_vals[SLOT_MIN]  = ld_min;
        ld_mask[SLOT_HOUR] = 1'b1; ld_vals[SLOT_HOUR] = ld_hour;
        ld_mask[SLOT_WDAY] = 1'b1; ld_vals[SLOT_WDAY] = ld_wday + 8'd1;
        ld_mask[SLOT_MDAY] = 1'b1; ld_vals[SLOT_MDAY] = ld_mday;
        ld_mask[SLOT_MON]  = 1'b1; ld_vals[SLOT_MON]  = ld_mon + 8'd1;
        ld_mask[SLOT_YEAR] = 1'b1; ld_vals[SLOT_YEAR] = ld_year;
    end

    rtc_time_store #(.TIME_BYTES(TIME_BYTES), .IDX_W(IDX_W)) u_time (
        .clk(clk), .rst_n(rst_n), .idx(cur_idx), .wr_en(dat_we),
        .wr_val(dat_wdata), .ld_en(ld_en), .ld_mask(ld_mask),
        .ld_vals(ld_vals), .rd_byte(time_byte)
    );

    rtc_status_regs #(.IDX_W(IDX_W), .BASE(TIME_BYTES)) u_stat (
        .clk(clk), .rst_n(rst_n), .idx(cur_idx), .wr_en(dat_we),
        .rd_en(dat_re), .wr_val(dat_wdata), .stat_a(stat_a),
        .stat_b(stat_b), .rd_byte(stat_byte), .reject(stat_bad),
        .pie_on(pie_on), .pie_off(pie_off)
    );

    rtc_periodic_timer #(.PERIOD(PERIOD_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(pie_on), .stop(pie_off),
        .running(running), .irq(irq)
    );

    // Capture read data on a read strobe and hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (dat_re) rd_data <= (cur_idx < IDX_W'(TIME_BYTES)) ? time_byte : stat_byte;
    end

    // Register the unsupported-access flag as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) bad_access <= 1'b0;
        else        bad_access <= idx_bad || stat_bad;
    end
endmodule

// File: rtl/rtc_regfile_chk.sv
// Assertion checker for rtc_regfile, bound to every instance of the top.
module rtc_regfile_chk #(
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned MAX_IDX = 13,
    parameter int unsigned ADDR_A  = 10,
    parameter int unsigned ADDR_B  = 11,
    parameter int unsigned ADDR_C  = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idx_we,
    input logic [7:0]       idx_wdata,
    input logic             dat_we,
    input logic             dat_re,
    input logic [7:0]       dat_wdata,
    input logic [7:0]       rd_data,
    input logic             bad_access,
    input logic             irq,
    input logic [IDX_W-1:0] cur_idx,
    input logic [7:0]       stat_a,
    input logic [7:0]       stat_b
);
    // R1
    idx_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we && idx_wdata > 8'(MAX_IDX)) |=> (bad_access && $stable(cur_idx)));
    // R3
    uip_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && !dat_we && cur_idx == IDX_W'(ADDR_A))
        |=> (stat_a[7] != $past(stat_a[7]) && rd_data == stat_a));
    // R4
    a_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && cur_idx == IDX_W'(ADDR_A) && dat_wdata != 8'h26)
        |=> (bad_access && $stable(stat_a)));
    // R7
    cd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && cur_idx >= IDX_W'(ADDR_C)) |=> rd_data == 8'h00);
    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R10
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_b[6]);
    // R10
    stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && cur_idx == IDX_W'(ADDR_B) && (dat_wdata & 8'hB7) == 8'h06
         && !dat_wdata[6]) |=> !irq);
endmodule

bind rtc_regfile rtc_regfile_chk #(
    .IDX_W(IDX_W), .MAX_IDX(NUM_LOC - 1), .ADDR_A(ADDR_A),
    .ADDR_B(ADDR_B), .ADDR_C(ADDR_C)
) u_chk (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata),
    .rd_data(rd_data), .bad_access(bad_access), .irq(irq),
    .cur_idx(cur_idx), .stat_a(stat_a), .stat_b(stat_b)
);

// File: tb/rtc_regfile_bench.sv
// Self-checking bench for rtc_regfile: sweeps of all write values against a
// byte model, load-port mapping, and interrupt timing by edge counting.
module rtc_regfile_bench;
    localparam int P = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic idx_we = 0, dat_we = 0, dat_re = 0, ld_en = 0;
    logic [7:0] idx_wdata = 0, dat_wdata = 0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_wday = 0;
    logic [7:0] ld_mday = 0, ld_mon = 0, ld_year = 0;
    logic [7:0] rd_data;
    logic bad_access, irq;

    int checks = 0, errors = 0;
    int cyc = 0, irq_cnt = 0, last_irq = 0, wide = 0, wr_edge = 0;
    logic prev_irq = 0;
    logic last_bad;
    logic [7:0] last_rd;
    logic [7:0] mem [14];

    rtc_regfile #(.NUM_LOC(14), .PERIOD_CYCLES(P)) u_rtc_regfile (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
        .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata),
        .rd_data(rd_data), .bad_access(bad_access), .ld_en(ld_en),
        .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_wday(ld_wday), .ld_mday(ld_mday), .ld_mon(ld_mon),
        .ld_year(ld_year), .irq(irq)
    );

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // Interrupt monitor on the falling edge
    always @(negedge clk) begin
        if (irq) begin
            irq_cnt  <= irq_cnt + 1;
            last_irq <= cyc;
            if (prev_irq) wide <= wide + 1;
        end
        prev_irq <= irq;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_idx(input logic [7:0] v);
        @(negedge clk); idx_we = 1; idx_wdata = v;
        @(negedge clk); idx_we = 0; last_bad = bad_access;
    endtask

    task automatic wr_dat(input logic [7:0] v);
        @(negedge clk); dat_we = 1; dat_wdata = v;
        @(posedge clk); #1 wr_edge = cyc;
        @(negedge clk); dat_we = 0; last_bad = bad_access;
    endtask

    task automatic rd();
        @(negedge clk); dat_re = 1;
        @(negedge clk); dat_re = 0; last_rd = rd_data;
    endtask

    // Expected read value of location i; a read of A flips the model's flag
    function automatic logic [7:0] model_rd(input int i);
        if (i == 10) begin mem[10][7] = ~mem[10][7]; return mem[10]; end
        if (i >= 12) return 8'h00;
        return mem[i];
    endfunction

    task automatic wait_irq(input int prev);
        for (int k = 0; k < 4 * P && irq_cnt == prev; k++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 14; i++) mem[i] = 8'h00;
        mem[10] = 8'h26; mem[11] = 8'h46;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // Reset state
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset bad", 8'(bad_access), 8'h00);
        wr_idx(10); check("R1 valid idx", 8'(last_bad), 8'h00);
        rd(); check("R3 first A read", last_rd, 8'hA6);
        rd(); check("R3 second A read", last_rd, 8'h26);
        wr_idx(11); rd(); check("R5 B reset", last_rd, 8'h46);

        // C and D
        for (int i = 12; i < 14; i++) begin
            wr_idx(8'(i)); rd(); check("R7 read zero", last_rd, 8'h00);
            wr_dat(8'h55); check("R7 write flagged", 8'(last_bad), 8'h01);
            rd(); check("R7 still zero", last_rd, 8'h00);
        end

        // Time/date bytes
        for (int i = 0; i < 10; i++) begin
            wr_idx(8'(i)); wr_dat(8'(i * 37 + 5)); mem[i] = 8'(i * 37 + 5);
            check("R2 write no flag", 8'(last_bad), 8'h00);
        end
        for (int i = 0; i < 10; i++) begin
            wr_idx(8'(i)); rd(); check("R2 readback", last_rd, mem[i]);
            rd(); check("R2 repeat read", last_rd, mem[i]);
        end

        // Index sweep over every value
        for (int v = 0; v < 256; v++) begin
            wr_idx(3);
            wr_idx(8'(v));
            check("R1 index flag", 8'(last_bad), (v > 13) ? 8'h01 : 8'h00);
            rd();
            check("R1 selected location", last_rd, model_rd((v > 13) ? 3 : v));
        end

        // Status A write sweep
        wr_idx(10);
        for (int v = 0; v < 256; v++) begin
            wr_dat(8'(v));
            check("R4 A write flag", 8'(last_bad), (v != 8'h26) ? 8'h01 : 8'h00);
            if (v == 8'h26) mem[10] = 8'h26;
            rd(); check("R4 A contents", last_rd, model_rd(10));
        end

        // Status B write sweep
        wr_idx(11);
        for (int v = 0; v < 256; v++) begin
            logic ok;
            ok = (8'(v) & 8'hB7) == 8'h06;
            wr_dat(8'(v));
            check("R6 B write flag", 8'(last_bad), ok ? 8'h00 : 8'h01);
            if (ok) mem[11] = 8'(v);
            rd(); check("R6 B contents", last_rd, mem[11]);
        end

        // Load port
        wr_idx(1); wr_dat(8'hC3);
        @(negedge clk);
        ld_en = 1; ld_sec = 8'd45; ld_min = 8'd17; ld_hour = 8'd23;
        ld_wday = 8'd3; ld_mday = 8'd28; ld_mon = 8'd11; ld_year = 8'd124;
        @(negedge clk); ld_en = 0;
        wr_idx(0); rd(); check("R8 seconds", last_rd, 8'd45);
        wr_idx(1); rd(); check("R8 slot 1 untouched", last_rd, 8'hC3);
        wr_idx(2); rd(); check("R8 minutes", last_rd, 8'd17);
        wr_idx(4); rd(); check("R8 hours", last_rd, 8'd23);
        wr_idx(6); rd(); check("R8 weekday one-based", last_rd, 8'd4);
        wr_idx(7); rd(); check("R8 day of month", last_rd, 8'd28);
        wr_idx(8); rd(); check("R8 month one-based", last_rd, 8'd12);
        wr_idx(9); rd(); check("R8 year", last_rd, 8'd124);

        // Periodic timer: stopped state
        wr_idx(11); wr_dat(8'h06);
        begin
            int n0;
            n0 = irq_cnt;
            repeat (3 * P) @(negedge clk);
            check("R10 stopped no irq", 8'(irq_cnt - n0), 8'h00);
        end

        // Enable and measure
        begin
            int n0, t0;
            n0 = irq_cnt;
            wr_dat(8'h46);
            wait_irq(n0);
            check("R9 first pulse delay", 8'(last_irq - wr_edge), 8'(P));
            n0 = irq_cnt; t0 = last_irq;
            wait_irq(n0);
            check("R9 pulse spacing", 8'(last_irq - t0), 8'(P));
            // Re-enable while running: no restart
            n0 = irq_cnt; t0 = last_irq;
            repeat (P / 3) @(negedge clk);
            wr_dat(8'h4E);
            check("R10 re-enable accepted", 8'(last_bad), 8'h00);
            wait_irq(n0);
            check("R10 no restart", 8'(last_irq - t0), 8'(P));
            // Rejected write with enable clear: timer keeps running
            n0 = irq_cnt; t0 = last_irq;
            wr_dat(8'h05);
            check("R6 rejected B write", 8'(last_bad), 8'h01);
            wait_irq(n0);
            check("R6 timer unaffected", 8'(last_irq - t0), 8'(P));
            // Stop
            n0 = irq_cnt;
            wr_dat(8'h0E);
            repeat (3 * P) @(negedge clk);
            check("R10 stop immediate", 8'(irq_cnt - n0), 8'h00);
            check("R9 single-cycle pulses", 8'(wide), 8'h00);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule